// File: doc/BRIEF.md
# External Bus Address-Latch and Code-Fetch Strobe Generator

This block drives the two timing strobes of a multiplexed external memory bus. One is an active-high address latch strobe (`ale`), which marks the moment when external logic should capture the low address byte. The other is an active-low code-fetch read strobe (`psen_n`). The block runs on the oscillator clock. It follows a machine-cycle phase count that the core supplies, and each machine cycle is split into two equal halves. Every half holds three slots in order: a latch slot, a setup slot and a fetch slot.

The core also supplies three per-cycle qualifiers: an external data-move cycle, a code-table read and external code execution. The block uses them to shape the strobes. An external data-move cycle suppresses the address latch pulse of its second half and both fetch strobes. A one-bit configuration register can hold the latch strobe parked high to cut bus noise. While it does so, pulses still appear in data-move and table-read cycles. When code runs from external memory, the parked setting is overridden.

Internally, a state machine tracks the slot. Its states are `ST_IDLE` (reset only), `ST_LATCH`, `ST_SETUP` and `ST_FETCH`. From reset the machine takes the transition *start* (`ST_IDLE` to the decoded slot). After that it follows *latch-to-setup*, *setup-to-fetch* and *fetch-to-latch* as the phase advances. An out-of-range phase takes the transition *abort*, which returns it to `ST_IDLE`.

Top module: `ale_psen_strobe_gen`

## Requirements
- R1: While `rst_n` is low, `ale` is 0 and `psen_n` is 1, and the parking bit clears to 0.
- R2: Let `hp = phase mod (CYC_LEN/2)`. With no qualifier set and parking off, `ale` is 1 exactly when `hp < ALE_W` (two pulses per machine cycle, each `ALE_W` clocks wide) and 0 otherwise.
- R3: With `ext_exec` = 1 and `movx_cyc` = 0, `psen_n` is 0 exactly when `hp >= PSEN_START`. With `ext_exec` = 0, `psen_n` stays 1.
- R4: In a cycle with `movx_cyc` = 1, the latch pulse of the second half (`phase >= CYC_LEN/2`) is suppressed and the first-half pulse is kept.
- R5: In a cycle with `movx_cyc` = 1, `psen_n` stays 1 even while `ext_exec` = 1.
- R6: A write (`cfg_we` = 1) loads `cfg_wbit` into the parking bit only when `cfg_addr` equals `CFG_ADDR` (default 8'h8E). A write to any other address leaves the `ale` pattern unchanged.
- R7: With the parking bit at 1, and with `ext_exec`, `movx_cyc` and `movc_cyc` all 0, `ale` is held at 1.
- R8: With the parking bit at 1, a cycle with `movx_cyc` or `movc_cyc` set gives the same `ale` pattern as with parking off.
- R9: With `ext_exec` = 1, the parking bit has no effect on `ale`.
- R10: `ale` and `psen_n` follow the `phase` and qualifier values sampled at the previous rising clock edge. A register write takes effect on the outputs in the same cycle as the new qualifiers of that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase | input | PH_W | Oscillator phase within the machine cycle, 0 to CYC_LEN-1 |
| movx_cyc | input | 1 | Current machine cycle is an external data-move access |
| movc_cyc | input | 1 | Current machine cycle is a code-table read |
| ext_exec | input | 1 | Code is being executed from external memory |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration write address |
| cfg_wbit | input | 1 | Value written to the parking bit |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Code-fetch read strobe, active low |

## Verification
The bench builds the block with a 12-clock machine cycle, a 2-clock latch pulse and a fetch window that starts at slot 3. These values make both halves, the setup gap between latch and fetch, and the second-half suppression visible within a dozen clocks. Each qualifier mix is held for whole machine cycles, so every slot is seen under every mix. One sequence toggles the execution flag in mid-half to expose the one-register latency. The parking bit is written both at the matching address and at a neighbouring one.

// File: rtl/strobe_pkg.sv
package strobe_pkg;

    // Slot within one half machine cycle
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LATCH = 2'd1,
        ST_SETUP = 2'd2,
        ST_FETCH = 2'd3
    } strobe_state_e;

    // Per-cycle qualifiers supplied by the core
    typedef struct packed {
        logic movx;
        logic movc;
        logic ext;
    } cyc_flags_t;

endpackage

// File: rtl/strobe_slot_dec.sv
module strobe_slot_dec
    import strobe_pkg::*;
#(
    parameter int CYC_LEN    = 12,
    parameter int ALE_W      = 2,
    parameter int PSEN_START = 3,
    parameter int PH_W       = $clog2(CYC_LEN)
) (
    input  logic [PH_W-1:0] phase,
    output strobe_state_e   slot,
    output logic            second_half
);
    localparam int HALF = CYC_LEN / 2;
    localparam logic [PH_W-1:0] HALF_P  = PH_W'(HALF);
    localparam logic [PH_W-1:0] CYC_P   = PH_W'(CYC_LEN);
    localparam logic [PH_W-1:0] ALE_P   = PH_W'(ALE_W);
    localparam logic [PH_W-1:0] FETCH_P = PH_W'(PSEN_START);

    logic [PH_W-1:0] hp;

    always_comb begin
        second_half = (phase >= HALF_P);
        hp          = second_half ? (phase - HALF_P) : phase;
    end

    always_comb begin
        if (phase >= CYC_P) begin
            slot = ST_IDLE;
        end else if (hp < ALE_P) begin
            slot = ST_LATCH;
        end else if (hp < FETCH_P) begin
            slot = ST_SETUP;
        end else begin
            slot = ST_FETCH;
        end
    end

endmodule

// File: rtl/strobe_cfg_reg.sv
module strobe_cfg_reg #(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h8E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wbit,
    output logic              park
);
    logic hit;

    always_comb hit = we && (addr == CFG_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            park <= 1'b0;
        end else if (hit) begin
            park <= wbit;
        end
    end

endmodule

// File: rtl/strobe_gate_policy.sv
module strobe_gate_policy
    import strobe_pkg::*;
(
    input  cyc_flags_t flags,
    input  logic       park,
    input  logic       second_half,
    output logic       ale_drop,
    output logic       ale_park_hi,
    output logic       fetch_ok
);
    always_comb begin
        // A data-move cycle loses its second address latch pulse
        ale_drop    = flags.movx && second_half;
        // Parking holds the strobe high unless the bus is in use;
        // external execution always wins over parking
        ale_park_hi = park && !flags.ext && !flags.movx && !flags.movc;
        // Fetch strobes only when running externally and not moving data
        fetch_ok    = flags.ext && !flags.movx;
    end

endmodule

// File: rtl/ale_psen_strobe_gen.sv
module ale_psen_strobe_gen
    import strobe_pkg::*;
#(
    parameter int                CYC_LEN    = 12,
    parameter int                ALE_W      = 2,
    parameter int                PSEN_START = 3,
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] CFG_ADDR   = 8'h8E,
    parameter int                PH_W       = $clog2(CYC_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PH_W-1:0]   phase,
    input  logic              movx_cyc,
    input  logic              movc_cyc,
    input  logic              ext_exec,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_wbit,
    output logic              ale,
    output logic              psen_n
);
    strobe_state_e state_q, state_d, slot_w;
    logic          half_w, half_q;
    cyc_flags_t    flags_q;
    logic          park_w;
    logic          drop_w, park_hi_w, fetch_ok_w;

    strobe_slot_dec #(
        .CYC_LEN    (CYC_LEN),
        .ALE_W      (ALE_W),
        .PSEN_START (PSEN_START),
        .PH_W       (PH_W)
    ) u_dec (
        .phase       (phase),
        .slot        (slot_w),
        .second_half (half_w)
    );

    strobe_cfg_reg #(
        .ADDR_W   (ADDR_W),
        .CFG_ADDR (CFG_ADDR)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wbit  (cfg_wbit),
        .park  (park_w)
    );

    strobe_gate_policy u_pol (
        .flags       (flags_q),
        .park        (park_w),
        .second_half (half_q),
        .ale_drop    (drop_w),
        .ale_park_hi (park_hi_w),
        .fetch_ok    (fetch_ok_w)
    );

    // Next-state: transitions follow the decoded slot of the sampled phase
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = slot_w;                      // start
            ST_LATCH: state_d = slot_w;                      // latch-to-setup / hold / abort
            ST_SETUP: state_d = slot_w;                      // setup-to-fetch / abort
            ST_FETCH: state_d = slot_w;                      // fetch-to-latch / abort
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register with qualifier capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            half_q  <= 1'b0;
            flags_q <= '0;
        end else begin
            state_q <= state_d;
            half_q  <= half_w;
            flags_q <= '{movx: movx_cyc, movc: movc_cyc, ext: ext_exec};
        end
    end

    // Output decode
    always_comb begin
        ale    = 1'b0;
        psen_n = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                ale    = 1'b0;
                psen_n = 1'b1;
            end
            ST_LATCH: begin
                ale    = park_hi_w || !drop_w;
                psen_n = 1'b1;
            end
            ST_SETUP: begin
                ale    = park_hi_w;
                psen_n = 1'b1;
            end
            ST_FETCH: begin
                ale    = park_hi_w;
                psen_n = !fetch_ok_w;
            end
            default: begin
                ale    = 1'b0;
                psen_n = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/strobe_gen_sva.sv
module strobe_gen_sva #(
    parameter int CYC_LEN    = 12,
    parameter int ALE_W      = 2,
    parameter int PSEN_START = 3,
    parameter int PH_W       = $clog2(CYC_LEN)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PH_W-1:0] phase,
    input logic            movx_cyc,
    input logic            movc_cyc,
    input logic            ext_exec,
    input logic            park,
    input logic            ale,
    input logic            psen_n
);
    localparam int HALF = CYC_LEN / 2;
    localparam logic [PH_W-1:0] HALF_P = PH_W'(HALF);
    localparam logic [PH_W-1:0] ALE_P  = PH_W'(ALE_W);

    logic            in_range;
    logic            upper;
    logic [PH_W-1:0] hp_c;

    always_comb begin
        in_range = (phase < PH_W'(CYC_LEN));
        upper    = (phase >= HALF_P);
        hp_c     = upper ? (phase - HALF_P) : phase;
    end

    // R1: idle strobe levels while reset is held
    always @(negedge clk) begin
        if (!rst_n) begin
            a_r1_reset_idle: assert (ale == 1'b0 && psen_n == 1'b1);
        end
    end

    // R3: no fetch strobe when running from internal memory
    a_r3_no_fetch_internal: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ext_exec) |-> psen_n);

    // R4: second-half latch pulse dropped in a data-move cycle
    a_r4_movx_drop_second: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(movx_cyc) && $past(upper)) |-> !ale);

    // R5: fetch strobes dropped in a data-move cycle
    a_r5_movx_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        $past(movx_cyc) |-> psen_n);

    // R7: parked strobe stays high when the bus is quiet
    a_r7_parked_high: assert property (@(posedge clk) disable iff (!rst_n)
        (park && $past(in_range) && !$past(ext_exec) && !$past(movx_cyc) && !$past(movc_cyc)) |-> ale);

    // R9: external execution ignores parking outside the latch slot
    a_r9_ext_override: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ext_exec) && $past(in_range) && ($past(hp_c) >= ALE_P)) |-> !ale);

endmodule

bind ale_psen_strobe_gen strobe_gen_sva #(
    .CYC_LEN    (CYC_LEN),
    .ALE_W      (ALE_W),
    .PSEN_START (PSEN_START),
    .PH_W       (PH_W)
) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .movx_cyc (movx_cyc),
    .movc_cyc (movc_cyc),
    .ext_exec (ext_exec),
    .park     (park_w),
    .ale      (ale),
    .psen_n   (psen_n)
);

// File: tb/ale_psen_strobe_gen_test.sv
`timescale 1ns/1ps
module ale_psen_strobe_gen_test;
    localparam int CYC_LEN    = 12;
    localparam int ALE_W      = 2;
    localparam int PSEN_START = 3;
    localparam int HALF       = CYC_LEN / 2;
    localparam int PH_W       = $clog2(CYC_LEN);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PH_W-1:0] phase = '0;
    logic            movx_cyc = 1'b0, movc_cyc = 1'b0, ext_exec = 1'b0;
    logic            cfg_we = 1'b0;
    logic [7:0]      cfg_addr = 8'h00;
    logic            cfg_wbit = 1'b0;
    logic            ale, psen_n;

    int checks = 0, failures = 0, cycles = 0;
    bit done = 0;

    // Reference model state
    int    ph = 0;
    bit    m_park = 0;
    bit    exp_ale = 0, exp_psen = 1;
    string tag_ale = "R1", tag_psen = "R1", scen = "reset";
    bit    w_pend = 0;
    logic [7:0] w_addr = 8'h00;
    bit    w_bit = 0;

    ale_psen_strobe_gen #(
        .CYC_LEN(CYC_LEN), .ALE_W(ALE_W), .PSEN_START(PSEN_START)
    ) uut (
        .clk(clk), .rst_n(rst_n), .phase(phase),
        .movx_cyc(movx_cyc), .movc_cyc(movc_cyc), .ext_exec(ext_exec),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wbit(cfg_wbit),
        .ale(ale), .psen_n(psen_n)
    );

    always #2 clk = ~clk;

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
            finish_run();
        end
    end

    // Compare outputs against the model (called at a falling edge)
    task automatic compare();
        checks++;
        if (ale !== exp_ale) begin
            failures++;
            $display("FAIL %s [%s] ale actual=%b expected=%b", tag_ale, scen, ale, exp_ale);
        end
        checks++;
        if (psen_n !== exp_psen) begin
            failures++;
            $display("FAIL %s [%s] psen_n actual=%b expected=%b", tag_psen, scen, psen_n, exp_psen);
        end
    endtask

    // One oscillator clock: check, then drive and predict the next edge (R10)
    task automatic step(input bit mx, input bit mc, input bit ex, input bit in_rst);
        int hp, hf;
        bit parked, pulse;
        @(negedge clk);
        compare();
        rst_n    = !in_rst;
        phase    = PH_W'(ph);
        movx_cyc = mx;
        movc_cyc = mc;
        ext_exec = ex;
        cfg_we   = w_pend;
        cfg_addr = w_addr;
        cfg_wbit = w_bit;
        if (in_rst) begin
            m_park = 0;
            exp_ale = 0; exp_psen = 1; tag_ale = "R1"; tag_psen = "R1";
        end else begin
            if (w_pend && w_addr == 8'h8E) m_park = w_bit; // R6
            hp = ph % HALF;
            hf = ph / HALF;
            parked = m_park && !ex && !mx && !mc;
            pulse  = (hp < ALE_W) && !(mx && hf == 1);
            exp_ale  = parked ? 1'b1 : pulse;
            exp_psen = !(ex && !mx && hp >= PSEN_START);
            if (parked)                 tag_ale = "R7";
            else if (mx && hf == 1)     tag_ale = "R4";
            else if (m_park && ex)      tag_ale = "R9";
            else if (m_park)            tag_ale = "R8";
            else                        tag_ale = "R2";
            tag_psen = mx ? "R5" : "R3";
        end
        w_pend = 0;
        ph = (ph + 1) % CYC_LEN;
    endtask

    task automatic run(input string s, input bit mx, input bit mc, input bit ex, input int n);
        scen = s;
        for (int i = 0; i < n; i++) step(mx, mc, ex, 0);
    endtask

    task automatic write_cfg(input logic [7:0] a, input bit b);
        w_pend = 1; w_addr = a; w_bit = b;
    endtask

    initial begin
        // R1: reset state
        scen = "R1_reset";
        for (int i = 0; i < 4; i++) step(0, 0, 0, 1);
        ph = 0;
        run("R2_internal", 0, 0, 0, 2 * CYC_LEN);
        run("R3_external", 0, 0, 1, 2 * CYC_LEN);
        run("R4_R5_ext_movx", 1, 0, 1, CYC_LEN);
        run("R4_int_movx", 1, 0, 0, CYC_LEN);
        run("R2_movc_unparked", 0, 1, 0, CYC_LEN);
        // R6: write at a non-matching address is ignored
        write_cfg(8'h8F, 1);
        run("R6_wrong_addr", 0, 0, 0, CYC_LEN);
        write_cfg(8'h0E, 1);
        run("R6_wrong_addr2", 0, 0, 0, CYC_LEN);
        // R6/R7: matching write parks the strobe
        write_cfg(8'h8E, 1);
        run("R7_parked", 0, 0, 0, 2 * CYC_LEN);
        run("R8_parked_movc", 0, 1, 0, CYC_LEN);
        run("R8_parked_movx", 1, 0, 0, CYC_LEN);
        run("R9_parked_ext", 0, 0, 1, 2 * CYC_LEN);
        run("R9_parked_ext_movx", 1, 0, 1, CYC_LEN);
        run("R7_parked_again", 0, 0, 0, CYC_LEN);
        // R6: clear parking
        write_cfg(8'h8E, 0);
        run("R6_unpark", 0, 0, 0, CYC_LEN);
        // R10: mid-half toggling of the execution flag
        scen = "R10_toggle";
        for (int i = 0; i < 3 * CYC_LEN; i++) step(0, 0, (i % 5) < 2, 0);
        // R10: parking write landing mid-cycle
        write_cfg(8'h8E, 1);
        run("R10_write_mid", 0, 0, 0, 5);
        write_cfg(8'h8E, 0);
        run("R10_unpark_mid", 0, 0, 0, CYC_LEN + 7);
        @(negedge clk);
        compare();
        finish_run();
    end

endmodule